// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a single-clock synchronous memory for on-chip use. Each word is 36 bits wide and is divided into four 9-bit lanes, each holding 8 data bits and one parity bit. Every request input is captured on the rising clock edge. This covers the address, write data, the three select inputs and the write controls. Reads leave through an output register, so read data and its valid flag appear one edge after the request is captured.

Writes can cover any mix of lanes. An all-lanes write control overrides the per-lane controls. The per-lane strobes apply only while a separate lane-write enable is active. A cycle that asks for no lane becomes a read. A write is stored at the edge that follows its capture, so a read issued on the next cycle already returns the new word.

There are three select inputs, and any one of them can block a cycle. The select state moves through the pipeline with the request, so a bank of these memories adds no latency when used for depth expansion. An asynchronous output enable and a sleep input gate the visible data and valid without waiting for a clock edge. The burst address counter lives in a separate block that drives the address port.

Top module: `sram_pipe_top`

## Requirements
- R1: When `all_wr_n_i` is low in a selected cycle, all four lanes of the addressed word are written, whatever `lane_wr_en_n_i` and `lane_sel_n_i` are.
- R2: With `all_wr_n_i` high and `lane_wr_en_n_i` low, lane i is written exactly when `lane_sel_n_i[i]` is low. Lane i occupies `wdata_i`/`rdata_o` bits [9i+8:9i]. Bit 9i+8 is that lane's parity bit. Unwritten lanes keep their old contents.
- R3: When no lane is requested (`all_wr_n_i` high, and either `lane_wr_en_n_i` high or all `lane_sel_n_i` bits high), a selected cycle is a read. When `lane_wr_en_n_i` is high the lane strobes are ignored.
- R4: A read request driven before clock edge k is captured at edge k. Its data and `rdata_vld_o` high are visible after edge k+1 and stay until edge k+2. A write produces `rdata_vld_o` low in that slot.
- R5: A read issued in the cycle right after a write to the same address returns the newly written word.
- R6: A cycle with `cs1_n_i` high, `cs2_i` low or `cs3_n_i` high writes nothing. In that cycle's data slot `rdata_vld_o` is low.
- R7: `oe_n_i` high forces `rdata_vld_o` low and `rdata_o` to zero at once, with no clock edge. Whenever `rdata_vld_o` is low, `rdata_o` is zero.
- R8: While `sleep_i` is high, captured requests neither read nor write, and `rdata_vld_o` is held low combinationally. Stored contents are kept.
- R9: After reset `rdata_vld_o` is low until the first selected read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| cs1_n_i | input | 1 | Select, active low |
| cs2_i | input | 1 | Select, active high |
| cs3_n_i | input | 1 | Select, active low |
| all_wr_n_i | input | 1 | Write all lanes, active low |
| lane_wr_en_n_i | input | 1 | Enables the per-lane strobes, active low |
| lane_sel_n_i | input | 4 | Per-lane write strobes, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Blocks accesses and hides the output |
| rdata_o | output | 36 | Read data, zero when not valid |
| rdata_vld_o | output | 1 | Read data valid |

## Verification
The clocked properties assume that every control input is at a known 0 or 1 at each rising edge. They also assume that a read which follows a write uses the memory only through the registered stage, never through an uncaptured address. The bench changes inputs only on falling edges, so each captured value is stable, and it reads only words it has already written. The combinational gating checks assume that `oe_n_i` and `sleep_i` may change at any time. The bench therefore toggles them between edges while a valid read word is being held.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/sram_pipe_capture.sv
module sram_pipe_capture
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NLANES = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [NLANES*LANE_W-1:0] wdata_i,
    input  logic                     cs1_n_i,
    input  logic                     cs2_i,
    input  logic                     cs3_n_i,
    input  logic                     all_wr_n_i,
    input  logic                     lane_wr_en_n_i,
    input  logic [NLANES-1:0]        lane_sel_n_i,
    input  logic                     sleep_i,
    output op_e                      op_q,
    output logic [ADDR_W-1:0]        addr_q,
    output logic [NLANES*LANE_W-1:0] wdata_q,
    output logic [NLANES-1:0]        mask_q
);
    localparam int WORD_W = NLANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic [NLANES-1:0] mask;
    } cap_t;

    cap_t cap_d, cap_q;
    logic selected;
    logic [NLANES-1:0] req_mask;

    always_comb begin
        selected = !cs1_n_i && cs2_i && !cs3_n_i && !sleep_i;
        if (!all_wr_n_i)
            req_mask = '1;
        else if (!lane_wr_en_n_i)
            req_mask = ~lane_sel_n_i;
        else
            req_mask = '0;
        cap_d      = cap_q;
        cap_d.addr = addr_i;
        cap_d.data = wdata_i;
        cap_d.mask = selected ? req_mask : '0;
        if (!selected)
            cap_d.op = OP_IDLE;
        else if (|req_mask)
            cap_d.op = OP_WRITE;
        else
            cap_d.op = OP_READ;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '{op: OP_IDLE, addr: '0, data: '0, mask: '0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign op_q    = cap_q.op;
    assign addr_q  = cap_q.addr;
    assign wdata_q = cap_q.data;
    assign mask_q  = cap_q.mask;

    a_r1_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_wr_n_i && !cs1_n_i && cs2_i && !cs3_n_i && !sleep_i)
        |=> (op_q == OP_WRITE && (&mask_q)));

    a_r6_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cs1_n_i || !cs2_i || cs3_n_i) |=> (op_q == OP_IDLE && mask_q == '0));

    a_r8_sleep_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (op_q == OP_IDLE));

    a_r3_read_when_no_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (all_wr_n_i && lane_wr_en_n_i && !cs1_n_i && cs2_i && !cs3_n_i && !sleep_i)
        |=> (op_q == OP_READ));
endmodule

// File: rtl/sram_pipe_array.sv
module sram_pipe_array #(
    parameter int ADDR_W = 6,
    parameter int NLANES = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     we_i,
    input  logic [NLANES-1:0]        mask_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [NLANES*LANE_W-1:0] wdata_i,
    output logic [NLANES*LANE_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i && mask_i[g])
                mem_q[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
        end

        assign rdata_o[g*LANE_W +: LANE_W] = mem_q[addr_i];
    end
endmodule

// File: rtl/sram_pipe_out.sv
module sram_pipe_out
    import sram_pipe_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op_i,
    input  logic [WORD_W-1:0] rdata_i,
    input  logic              oe_n_i,
    input  logic              sleep_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              rdata_vld_o
);
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = (op_i == OP_READ);
        if (op_i == OP_READ)
            out_d.data = rdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{vld: 1'b0, data: '0};
        end else begin
            out_q <= out_d;
        end
    end

    always_comb begin
        rdata_vld_o = out_q.vld && !oe_n_i && !sleep_i;
        rdata_o     = rdata_vld_o ? out_q.data : '0;
    end

    a_r4_read_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_READ) |=> out_q.vld);

    a_r4_nonread_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_READ) |=> !out_q.vld);

    always_comb begin
        if (rst_n && (oe_n_i === 1'b1))
            a_r7_oe_hides: assert (!rdata_vld_o && rdata_o == '0);
        if (rst_n && (sleep_i === 1'b1))
            a_r8_sleep_hides: assert (!rdata_vld_o);
    end
endmodule

// File: rtl/sram_pipe_top.sv
module sram_pipe_top
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NLANES = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [NLANES*LANE_W-1:0] wdata_i,
    input  logic                     cs1_n_i,
    input  logic                     cs2_i,
    input  logic                     cs3_n_i,
    input  logic                     all_wr_n_i,
    input  logic                     lane_wr_en_n_i,
    input  logic [NLANES-1:0]        lane_sel_n_i,
    input  logic                     oe_n_i,
    input  logic                     sleep_i,
    output logic [NLANES*LANE_W-1:0] rdata_o,
    output logic                     rdata_vld_o
);
    localparam int WORD_W = NLANES * LANE_W;

    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic [NLANES-1:0] mask_q;
    logic [WORD_W-1:0] arr_rdata;

    sram_pipe_capture #(.ADDR_W(ADDR_W), .NLANES(NLANES), .LANE_W(LANE_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
        .cs1_n_i(cs1_n_i), .cs2_i(cs2_i), .cs3_n_i(cs3_n_i),
        .all_wr_n_i(all_wr_n_i), .lane_wr_en_n_i(lane_wr_en_n_i),
        .lane_sel_n_i(lane_sel_n_i), .sleep_i(sleep_i),
        .op_q(op_q), .addr_q(addr_q), .wdata_q(wdata_q), .mask_q(mask_q)
    );

    sram_pipe_array #(.ADDR_W(ADDR_W), .NLANES(NLANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .we_i(op_q == OP_WRITE), .mask_i(mask_q),
        .addr_i(addr_q), .wdata_i(wdata_q), .rdata_o(arr_rdata)
    );

    sram_pipe_out #(.WORD_W(WORD_W)) u_out (
        .clk(clk), .rst_n(rst_n), .op_i(op_q), .rdata_i(arr_rdata),
        .oe_n_i(oe_n_i), .sleep_i(sleep_i),
        .rdata_o(rdata_o), .rdata_vld_o(rdata_vld_o)
    );

    a_r2_write_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_WRITE) |-> (mask_q != '0));
endmodule

// File: tb/sram_pipe_top_tb_top.sv
module sram_pipe_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    typedef struct packed {
        logic [23:0] tag;
        logic [5:0]  addr;
        logic [35:0] din;
        logic        cs;
        logic        gwn;
        logic        bwen;
        logic [3:0]  bwn;
        logic        ev;
        logic [35:0] ed;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{"R1 ", 6'd1, 36'h123456789, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 36'h0},
        '{"R5 ", 6'd1, 36'h0,         1'b1, 1'b1, 1'b1, 4'hF, 1'b1, 36'h123456789},
        '{"R2 ", 6'd1, 36'hFFFFFFFFF, 1'b1, 1'b1, 1'b0, 4'hE, 1'b0, 36'h0},
        '{"R2 ", 6'd1, 36'h0,         1'b1, 1'b1, 1'b1, 4'hF, 1'b1, 36'h1234567FF},
        '{"R3 ", 6'd1, 36'h0,         1'b1, 1'b1, 1'b1, 4'h0, 1'b1, 36'h1234567FF},
        '{"R1 ", 6'd2, 36'hABCDEF012, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 36'h0},
        '{"R6 ", 6'd2, 36'h0,         1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 36'h0},
        '{"R6 ", 6'd2, 36'h0,         1'b1, 1'b1, 1'b1, 4'hF, 1'b1, 36'hABCDEF012},
        '{"R6 ", 6'd2, 36'h0,         1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 36'h0},
        '{"R2 ", 6'd2, 36'hFFFFFFFFF, 1'b1, 1'b1, 1'b0, 4'h5, 1'b0, 36'h0},
        '{"R2 ", 6'd2, 36'h0,         1'b1, 1'b1, 1'b1, 4'hF, 1'b1, 36'hFFCDFFE12},
        '{"R4 ", 6'd3, 36'h5A5A5A5A5, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 36'h0},
        '{"R5 ", 6'd3, 36'h0,         1'b1, 1'b1, 1'b1, 4'hF, 1'b1, 36'h5A5A5A5A5},
        '{"R2 ", 6'd3, 36'h0,         1'b1, 1'b1, 1'b0, 4'h8, 1'b0, 36'h0},
        '{"R2 ", 6'd3, 36'h0,         1'b1, 1'b1, 1'b1, 4'hF, 1'b1, 36'h5A0000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [35:0] din = '0;
    logic        cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
    logic        gwn = 1'b1, bwen = 1'b1;
    logic [3:0]  bwn = 4'hF;
    logic        oe_n = 1'b0, sleep = 1'b0;
    logic [35:0] rdata;
    logic        rvld;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_pipe_top dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(din),
        .cs1_n_i(cs1_n), .cs2_i(cs2), .cs3_n_i(cs3_n),
        .all_wr_n_i(gwn), .lane_wr_en_n_i(bwen), .lane_sel_n_i(bwn),
        .oe_n_i(oe_n), .sleep_i(sleep), .rdata_o(rdata), .rdata_vld_o(rvld)
    );

    task automatic check(input string req, input logic ev, input logic [35:0] ed);
        n_chk++;
        if (rvld !== ev || rdata !== (ev ? ed : 36'h0)) begin
            n_bad++;
            $display("FAIL %s: got vld=%0b data=%h, expected vld=%0b data=%h",
                     req, rvld, rdata, ev, ev ? ed : 36'h0);
        end
    endtask

    task automatic drv(input logic [5:0] a, input logic [35:0] d, input logic c1n,
                       input logic c2, input logic c3n, input logic g,
                       input logic be, input logic [3:0] b);
        addr = a; din = d; cs1_n = c1n; cs2 = c2; cs3_n = c3n;
        gwn = g; bwen = be; bwn = b;
    endtask

    task automatic idle();
        drv(6'd0, 36'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF);
    endtask

    task automatic rd(input logic [5:0] a);
        drv(a, 36'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", 1'b0, 36'h0);

        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2)
                check(string'(TBL[i-2].tag), TBL[i-2].ev, TBL[i-2].ed);
            if (i < NV)
                drv(TBL[i].addr, TBL[i].din, !TBL[i].cs ? 1'b0 : 1'b0,
                    TBL[i].cs, 1'b0, TBL[i].gwn, TBL[i].bwen, TBL[i].bwn);
            else
                idle();
            @(negedge clk);
        end

        // R7: output enable acts between edges on a held read word
        rd(6'd1);
        @(negedge clk); idle();
        @(negedge clk);
        check("R7", 1'b1, 36'h1234567FF);
        oe_n = 1'b1; #1;
        check("R7", 1'b0, 36'h0);
        oe_n = 1'b0; #1;
        check("R7", 1'b1, 36'h1234567FF);
        // R8: sleep hides the held word without a clock
        sleep = 1'b1; #1;
        check("R8", 1'b0, 36'h0);
        sleep = 1'b0; #1;
        check("R8", 1'b1, 36'h1234567FF);

        // R6: third select blocks a write; first select blocks a read
        @(negedge clk);
        drv(6'd1, 36'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF);
        @(negedge clk); rd(6'd1);
        @(negedge clk); drv(6'd1, 36'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF);
        @(negedge clk);
        check("R6", 1'b1, 36'h1234567FF);
        idle();
        @(negedge clk);
        check("R6", 1'b0, 36'h0);

        // R8: sleep blocks a write and a read, contents kept
        sleep = 1'b1;
        drv(6'd3, 36'hFFFFFFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF);
        @(negedge clk); rd(6'd3);
        @(negedge clk); sleep = 1'b0; idle();
        @(negedge clk);
        check("R8", 1'b0, 36'h0);
        rd(6'd3);
        @(negedge clk); idle();
        @(negedge clk);
        check("R8", 1'b1, 36'h5A0000000);

        // R3: lane strobes low but lane-write enable high -> read, no write
        drv(6'd3, 36'hFFFFFFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0);
        @(negedge clk); idle();
        @(negedge clk);
        check("R3", 1'b1, 36'h5A0000000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule